// File: doc/BRIEF.md
# Reloading Timer Bank with Wide Free-Running Counter

This block holds three down-counting timers and one wide up-counter behind a simple single-cycle register bus. The first two timers are 16 bits wide and the third is 32 bits wide. Each of the three can reload from its load register whenever it passes zero, or simply wrap around. Each one raises a level interrupt when it passes zero, and that interrupt stays high until software writes to the timer's clear register.

Counting is paced by tick-enable strobes, not by separate clocks. Each down-counter picks either a fast or a slow strobe through a control bit. The wide counter is 40 bits and has a strobe of its own. Software enables it through a bit in its high-word register, and it never interrupts.

A load value of N gives one interrupt every N+1 selected ticks. To get a given interrupt rate, software writes the tick rate divided by that rate, minus one.

Each down-counter is a two-state machine. HALTED means the count is frozen. RUNNING means the count moves on every selected tick. A control write with bit 7 set takes the timer from HALTED to RUNNING, and a control write with bit 7 clear takes it from RUNNING back to HALTED. The wide counter has the same structure with the states OFF and COUNT. A write to its high word with bit 8 set moves it to COUNT, and a write with bit 8 clear moves it to OFF.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every count, load value, control field and wide count reads as zero, and all three interrupt outputs are low.
- R2: A write to a timer's load register sets both the load value and the live count, even while the timer is halted. Load registers sit at offsets 0x00, 0x20 and 0x80 for timers 1, 2 and 3. The live count reads at the load offset plus 4.
- R3: A timer's control register sits at the load offset plus 8. Bit 7 enables counting, bit 6 selects periodic reload, and bit 3 selects the tick source: set means the fast strobe, clear means the slow strobe. A running timer decrements only on cycles where its selected strobe is high. Control reads return these three bits in the same positions.
- R4: In periodic mode, a timer loaded with N passes zero after N+1 selected ticks, reloads N, and sets its interrupt in the same cycle. The next interrupt follows N+1 ticks later.
- R5: With bit 6 clear, a timer that passes zero wraps to all ones (0xFFFF for timers 1 and 2, 0xFFFFFFFF for timer 3), still sets its interrupt, and then keeps counting down.
- R6: A timer's interrupt stays high until any data value is written to its clear register, at the load offset plus 12. If the timer passes zero in the same cycle as that write, the interrupt stays set. Each timer's interrupt is independent of the others.
- R7: A halted timer keeps its count, whatever the strobes do.
- R8: Timers 1 and 2 keep only the low 16 bits of a written load value. Timer 3 keeps all 32 bits.
- R9: The wide counter advances by one on each cycle its own strobe is high, but only after bit 8 of its high-word register (offset 0x64) has been written as 1. Writing bit 8 as 0 stops it. Offset 0x60 reads count bits 31:0. Offset 0x64 reads count bits 39:32 in bits 7:0 and the enable in bit 8.
- R10: The wide counter never reloads. Writes to its low-word register are ignored, and the fast and slow strobes do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| tick_fast | input | 1 | Fast count-enable strobe |
| tick_slow | input | 1 | Slow count-enable strobe |
| tick_wide | input | 1 | Count-enable strobe for the wide counter |
| irq | output | 3 | Underflow interrupts of timers 1..3 (bit 0 = timer 1) |

## Verification
Every down-counter is swept in periodic mode over load values 0 to 4, and the count is read after each single tick. Comparing those reads against N minus the number of ticks separates an off-by-one in the period from a missing reload or a late interrupt.

Free-running runs from load 1 show whether the wrap goes to all ones at the correct width. Alternating fast and slow pulses under both source settings show whether the strobe selection is right. A clear write that lands in the same cycle as an underflow shows which of the two wins.

The wide counter is pulsed before and after its enable, and its low word is written. This shows whether it is gated correctly and whether it is safe from writes and from the other strobes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_CH   = 3;

    localparam int OFS_LOAD = 'h0;
    localparam int OFS_CNT  = 'h4;
    localparam int OFS_CTRL = 'h8;
    localparam int OFS_CLR  = 'hC;

    localparam int WIDE_LO  = 'h60;
    localparam int WIDE_HI  = 'h64;

    localparam int BIT_EN   = 7;
    localparam int BIT_PER  = 6;
    localparam int BIT_SRC  = 3;
    localparam int BIT_WEN  = 8;

    typedef enum logic {
        CH_HALTED  = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_e;

    typedef enum logic {
        WC_OFF   = 1'b0,
        WC_COUNT = 1'b1
    } wc_state_e;

    function automatic int chan_base(input int idx);
        case (idx)
            0:       return 'h00;
            1:       return 'h20;
            default: return 'h80;
        endcase
    endfunction

endpackage

// File: rtl/tick_timer_dec.sv
module tick_timer_dec
    import tick_timer_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_CH-1:0] ld_we,
    output logic [NUM_CH-1:0] ct_we,
    output logic [NUM_CH-1:0] cl_we,
    output logic              hi_we
);
    logic wr_stb;
    assign wr_stb = bus_sel & bus_wr;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(chan_base(i));
        assign ld_we[i] = wr_stb && (bus_addr == BASE + ADDR_W'(OFS_LOAD));
        assign ct_we[i] = wr_stb && (bus_addr == BASE + ADDR_W'(OFS_CTRL));
        assign cl_we[i] = wr_stb && (bus_addr == BASE + ADDR_W'(OFS_CLR));
    end

    assign hi_we = wr_stb && (bus_addr == ADDR_W'(WIDE_HI));

endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
    import tick_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_fast,
    input  logic          tick_slow,
    input  logic          ld_we,
    input  logic          ct_we,
    input  logic          cl_we,
    input  logic [CW-1:0] wval,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] load_o,
    output logic          en_o,
    output logic          per_o,
    output logic          src_o,
    output logic          irq_o
);
    ch_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] load_q;
    logic          per_q, src_q, irq_q;
    logic          tick_sel, uflow;

    assign tick_sel = src_q ? tick_fast : tick_slow;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_HALTED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (ct_we) st_d = wval[BIT_EN] ? CH_RUNNING : CH_HALTED;
    end

    // Output / datapath decision per state
    always_comb begin
        cnt_d = cnt_q;
        uflow = 1'b0;
        unique case (st_q)
            CH_HALTED:  cnt_d = cnt_q;
            CH_RUNNING: begin
                if (tick_sel) begin
                    if (cnt_q == '0) begin
                        uflow = 1'b1;
                        cnt_d = per_q ? load_q : '1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
        endcase
        if (ld_we) cnt_d = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_q <= '0;
            per_q  <= 1'b0;
            src_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (ld_we) load_q <= wval;
            if (ct_we) begin
                per_q <= wval[BIT_PER];
                src_q <= wval[BIT_SRC];
            end
            if (uflow)      irq_q <= 1'b1;
            else if (cl_we) irq_q <= 1'b0;
        end
    end

    assign count_o = cnt_q;
    assign load_o  = load_q;
    assign en_o    = (st_q == CH_RUNNING);
    assign per_o   = per_q;
    assign src_o   = src_q;
    assign irq_o   = irq_q;

endmodule

// File: rtl/tick_timer_wide.sv
module tick_timer_wide
    import tick_timer_pkg::*;
#(
    parameter int WW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_wide,
    input  logic          hi_we,
    input  logic          en_val,
    output logic [WW-1:0] count_o,
    output logic          en_o
);
    wc_state_e     st_q, st_d;
    logic [WW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WC_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (hi_we) st_d = en_val ? WC_COUNT : WC_OFF;
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (st_q)
            WC_OFF:   cnt_d = cnt_q;
            WC_COUNT: if (tick_wide) cnt_d = cnt_q + 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign en_o    = (st_q == WC_COUNT);

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tick_timer_pkg::*;
#(
    parameter int T12_W  = 16,
    parameter int T3_W   = 32,
    parameter int WIDE_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              tick_wide,
    output logic [NUM_CH-1:0] irq
);
    localparam int HI_W = WIDE_W - DATA_W;

    logic [NUM_CH-1:0] ld_we, ct_we, cl_we;
    logic              hi_we;
    logic [DATA_W-1:0] ch_cnt32  [NUM_CH];
    logic [DATA_W-1:0] ch_load32 [NUM_CH];
    logic [DATA_W-1:0] ch_ctrl32 [NUM_CH];
    logic [NUM_CH-1:0] ch_en;
    logic [WIDE_W-1:0] wide_cnt;
    logic              wide_en;
    logic [T12_W-1:0]  t1_cnt;

    tick_timer_dec u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .ld_we   (ld_we),
        .ct_we   (ct_we),
        .cl_we   (cl_we),
        .hi_we   (hi_we)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int CW = (i == NUM_CH - 1) ? T3_W : T12_W;
        logic [CW-1:0] cnt_w, load_w;
        logic          per_w, src_w;

        tick_timer_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_fast(tick_fast),
            .tick_slow(tick_slow),
            .ld_we    (ld_we[i]),
            .ct_we    (ct_we[i]),
            .cl_we    (cl_we[i]),
            .wval     (bus_wdata[CW-1:0]),
            .count_o  (cnt_w),
            .load_o   (load_w),
            .en_o     (ch_en[i]),
            .per_o    (per_w),
            .src_o    (src_w),
            .irq_o    (irq[i])
        );

        assign ch_cnt32[i]  = DATA_W'(cnt_w);
        assign ch_load32[i] = DATA_W'(load_w);
        assign ch_ctrl32[i] = DATA_W'({ch_en[i], per_w, 2'b00, src_w, 3'b000});
    end

    tick_timer_wide #(.WW(WIDE_W)) u_wide (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_wide(tick_wide),
        .hi_we    (hi_we),
        .en_val   (bus_wdata[BIT_WEN]),
        .count_o  (wide_cnt),
        .en_o     (wide_en)
    );

    assign t1_cnt = ch_cnt32[0][T12_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(chan_base(i) + OFS_LOAD)) bus_rdata = ch_load32[i];
                if (bus_addr == ADDR_W'(chan_base(i) + OFS_CNT))  bus_rdata = ch_cnt32[i];
                if (bus_addr == ADDR_W'(chan_base(i) + OFS_CTRL)) bus_rdata = ch_ctrl32[i];
            end
            if (bus_addr == ADDR_W'(WIDE_LO)) bus_rdata = wide_cnt[DATA_W-1:0];
            if (bus_addr == ADDR_W'(WIDE_HI))
                bus_rdata = DATA_W'(wide_cnt[WIDE_W-1:DATA_W]) | (DATA_W'(wide_en) << BIT_WEN);
        end
    end

    initial begin
        if (HI_W < 1 || HI_W > 8) $error("wide counter width must be 33..40");
    end

endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
    parameter int CW = 16,
    parameter int WW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_stb,
    input logic [7:0]    addr,
    input logic [CW-1:0] wd,
    input logic          irq0,
    input logic [CW-1:0] cnt0,
    input logic          en0,
    input logic [WW-1:0] wcnt
);
    AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == 8'h00) |=> (cnt0 == $past(wd)));                       // R2

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en0 && !wr_stb) |=> $stable(cnt0));                                      // R7

    AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq0) |-> ($past(cnt0) == '0 && $past(en0)));                        // R4

    AST_CLEAR_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == 8'h0C && !en0) |=> !irq0);                             // R6

    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt == $past(wcnt)) || (wcnt == $past(wcnt) + 1'b1));                    // R10

endmodule

bind tick_timer_bank tick_timer_bank_chk #(.CW(T12_W), .WW(WIDE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_stb(bus_sel & bus_wr),
    .addr  (bus_addr),
    .wd    (bus_wdata[T12_W-1:0]),
    .irq0  (irq[0]),
    .cnt0  (t1_cnt),
    .en0   (ch_en[0]),
    .wcnt  (wide_cnt)
);

// File: tb/tick_timer_bank_tb_top.sv
module tick_timer_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0, tick_slow = 1'b0, tick_wide = 1'b0;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tick_timer_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .tick_wide(tick_wide),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // which: 0 fast, 1 slow, 2 wide
    task automatic tick(input int which);
        @(negedge clk);
        if (which == 0) tick_fast = 1'b1;
        else if (which == 1) tick_slow = 1'b1;
        else tick_wide = 1'b1;
        @(negedge clk);
        tick_fast = 1'b0; tick_slow = 1'b0; tick_wide = 1'b0;
    endtask

    function automatic logic [7:0] base(input int c);
        return (c == 0) ? 8'h00 : (c == 1) ? 8'h20 : 8'h80;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 64'(irq), 0);
        for (int c = 0; c < 3; c++) begin
            rd(base(c) + 8'h0, v); chk("R1 load", v, 0);
            rd(base(c) + 8'h4, v); chk("R1 count", v, 0);
            rd(base(c) + 8'h8, v); chk("R1 ctrl", v, 0);
        end
        rd(8'h60, v); chk("R1 wide lo", v, 0);
        rd(8'h64, v); chk("R1 wide hi", v, 0);

        // R4 periodic sweep: every channel, loads 0..4
        for (int c = 0; c < 3; c++) begin
            for (int n = 0; n <= 4; n++) begin
                wr(base(c) + 8'h8, 32'h0);
                wr(base(c) + 8'hC, 32'h0);
                wr(base(c) + 8'h0, 32'(n));
                wr(base(c) + 8'h8, 32'hC8);
                for (int k = 1; k <= n + 1; k++) begin
                    tick(0);
                    rd(base(c) + 8'h4, v);
                    chk("R4 count", v, (k == n + 1) ? 64'(n) : 64'(n - k));
                    chk("R4 irq", 64'(irq[c]), (k == n + 1) ? 1 : 0);
                end
                wr(base(c) + 8'hC, 32'h5A5A);
                chk("R6 cleared", 64'(irq[c]), 0);
                for (int k = 1; k <= n + 1; k++) tick(0);
                chk("R4 second period irq", 64'(irq[c]), 1);
                rd(base(c) + 8'h4, v); chk("R4 reload", v, 64'(n));
                wr(base(c) + 8'h8, 32'h0);
                wr(base(c) + 8'hC, 32'h0);
            end
        end

        // R5 free-running wrap, timers 1 and 3
        for (int c = 0; c < 3; c += 2) begin
            wr(base(c) + 8'h0, 32'h1);
            wr(base(c) + 8'h8, 32'h88);
            tick(0);
            rd(base(c) + 8'h4, v); chk("R5 to zero", v, 0);
            chk("R5 no irq yet", 64'(irq[c]), 0);
            tick(0);
            rd(base(c) + 8'h4, v); chk("R5 wrap", v, (c == 0) ? 64'hFFFF : 64'hFFFF_FFFF);
            chk("R5 irq", 64'(irq[c]), 1);
            tick(0);
            rd(base(c) + 8'h4, v); chk("R5 continue", v, (c == 0) ? 64'hFFFE : 64'hFFFF_FFFE);
            wr(base(c) + 8'h8, 32'h0);
            wr(base(c) + 8'hC, 32'h0);
        end

        // R3 source selection on timer 2
        wr(8'h20, 32'd10);
        wr(8'h28, 32'hC0);
        rd(8'h28, v); chk("R3 ctrl read slow", v, 32'hC0);
        tick(0); rd(8'h24, v); chk("R3 fast ignored", v, 10);
        tick(1); rd(8'h24, v); chk("R3 slow counts", v, 9);
        wr(8'h28, 32'hC8);
        rd(8'h28, v); chk("R3 ctrl read fast", v, 32'hC8);
        tick(1); rd(8'h24, v); chk("R3 slow ignored", v, 9);
        tick(0); rd(8'h24, v); chk("R3 fast counts", v, 8);

        // R7 halted holds; R2 load while halted
        wr(8'h28, 32'h48);
        tick(0); tick(1);
        rd(8'h24, v); chk("R7 hold", v, 8);
        wr(8'h20, 32'd3);
        rd(8'h24, v); chk("R2 load sets count", v, 3);
        rd(8'h20, v); chk("R2 load read", v, 3);

        // R6 clear vs underflow in the same cycle, timer 1
        wr(8'h00, 32'h0);
        wr(8'h08, 32'hC8);
        tick(0);
        chk("R6 irq set", 64'(irq[0]), 1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'hFFFF;
        tick_fast = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_fast = 1'b0;
        chk("R6 underflow wins", 64'(irq[0]), 1);
        chk("R6 others untouched", 64'(irq[2:1]), 0);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h1234);
        chk("R6 clear any data", 64'(irq[0]), 0);

        // R8 widths
        wr(8'h00, 32'h0001_2345);
        rd(8'h00, v); chk("R8 t1 load width", v, 32'h2345);
        rd(8'h04, v); chk("R8 t1 count width", v, 32'h2345);
        wr(8'h80, 32'hDEAD_BEEF);
        rd(8'h84, v); chk("R8 t3 count width", v, 32'hDEAD_BEEF);

        // R9 / R10 wide counter
        tick(2); tick(2);
        rd(8'h60, v); chk("R9 off no count", v, 0);
        wr(8'h64, 32'h100);
        for (int k = 0; k < 5; k++) tick(2);
        tick(0); tick(1);
        rd(8'h60, v); chk("R10 only wide strobe", v, 5);
        rd(8'h64, v); chk("R9 hi read", v, 32'h100);
        wr(8'h60, 32'd777);
        rd(8'h60, v); chk("R10 lo write ignored", v, 5);
        wr(8'h64, 32'h0);
        tick(2);
        rd(8'h60, v); chk("R9 stopped", v, 5);
        rd(8'h64, v); chk("R9 hi disabled", v, 0);

        finished = 1;
        report();
    end

endmodule